// File: doc/BRIEF.md
# Multi-Cycle Shared-Resource Processor Datapath

This block is the 32-bit datapath of a load/store processor that spreads each instruction over several clock cycles. A single memory port serves both instruction fetch and data access, and a single ALU is reused across the cycles of an instruction. The ALU computes the incremented program counter, the effective address, the register-to-register result and the branch comparison. Registers between the cycles hold the fetched instruction, both source operands, the ALU result and the loaded word. The register file lives inside the block.

An external sequencer drives the block. In every cycle it supplies write enables, multiplexer selects and an ALU operation code. It reads back the opcode and function fields of the held instruction and the ALU zero flag. The memory sits outside the block. It answers a read combinationally from the address the block presents, and it takes a write at the clock edge while the write strobe is high.

Top module: `mc_datapath`

## Requirements
- R1: When `addr_sel` is 0 the memory address is the program counter; when 1 it is the held ALU result register.
- R2: The instruction register loads `mem_rdata` at a clock edge only while `ir_wr` is 1 and holds otherwise; `opcode` shows its bits 31:26 and `funct` its bits 5:0.
- R3: The ALU first operand is the program counter when `srca_sel` is 0 and the A register when 1. The second operand depends on `srcb_sel`: 00 gives the B register, 01 gives the constant 4, 10 gives the sign-extended instruction bits 15:0, and 11 gives that value shifted left by two.
- R4: The ALU operation depends on `alu_ctl`: 000 adds, 001 subtracts, 010 ANDs, 011 ORs, and 100 gives a signed set-less-than result of 0 or 1. Codes 101 to 111 yield zero. `zero` is 1 exactly when the ALU result is all zeros.
- R5: The A, B, ALU result and memory data registers load at every clock edge. A takes the register addressed by instruction bits 25:21, B the register addressed by bits 20:16, the ALU result register the ALU output, and the data register `mem_rdata`.
- R6: When `rf_wr` is 1 a register is written at the clock edge. The destination is bits 15:11 when `dst_sel` is 1 and bits 20:16 when it is 0. The data is the memory data register when `wb_sel` is 1 and the ALU result register when it is 0.
- R7: Register 0 always reads as zero; writes to it have no effect.
- R8: The program counter loads when `pc_wr` is 1, or when `pc_wr_cond` is 1 and `zero` is 1. `pc_src` picks the new value: 00 gives the ALU output, 01 the ALU result register, and 10 the jump target {PC[31:28], IR[25:0], 2'b00}. Otherwise the counter holds.
- R9: `mem_we` follows `mem_wr`, and `mem_wdata` is the B register.
- R10: Reset clears the program counter, the instruction register and the A, B, ALU result and data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_wr | input | 1 | Instruction register load enable |
| pc_wr | input | 1 | Unconditional program counter load |
| pc_wr_cond | input | 1 | Program counter load when zero flag set |
| pc_src | input | 2 | Program counter source select |
| addr_sel | input | 1 | Memory address select |
| srca_sel | input | 1 | ALU first operand select |
| srcb_sel | input | 2 | ALU second operand select |
| alu_ctl | input | 3 | ALU operation code |
| dst_sel | input | 1 | Register write address select |
| wb_sel | input | 1 | Register write data select |
| rf_wr | input | 1 | Register file write enable |
| mem_wr | input | 1 | Memory write request |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Held instruction bits 31:26 |
| funct | output | 6 | Held instruction bits 5:0 |
| zero | output | 1 | ALU result is zero |

## Verification
The register file cannot be reached from the ports. Every register value is therefore brought out through a store instruction, whose data passes through B and is checked on the memory write bus and in the bench memory. The bench itself acts as the sequencer and runs complete load, compute, store, branch and jump sequences. This drives branch targets built from negative offsets and a load whose base register plus a negative immediate lands on a data word. It also drives a write to register 0 followed by a store of that register. The bench tracks its own expected program counter and checks it against the fetch address of every instruction.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;
    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;
    localparam int RIDX_W  = $clog2(REG_CNT);

    typedef enum logic [2:0] {
        ALU_ADD = 3'b000,
        ALU_SUB = 3'b001,
        ALU_AND = 3'b010,
        ALU_OR  = 3'b011,
        ALU_SLT = 3'b100
    } alu_op_e;

    localparam logic [1:0] SRCB_REG   = 2'b00;
    localparam logic [1:0] SRCB_FOUR  = 2'b01;
    localparam logic [1:0] SRCB_IMM   = 2'b10;
    localparam logic [1:0] SRCB_IMMSH = 2'b11;

    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_HELD = 2'b01;
    localparam logic [1:0] PCS_JMP  = 2'b10;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] alu_out;
        logic [XLEN-1:0] mdr;
    } dp_state_t;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW       = 32,
    parameter int NREGS    = 32,
    parameter int RD_PORTS = 2,
    localparam int AW      = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic [RD_PORTS*AW-1:0] ra,
    output logic [RD_PORTS*DW-1:0] rd,
    input  logic                   we,
    input  logic [AW-1:0]          wa,
    input  logic [DW-1:0]          wd
);
    logic [DW-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs_q[wa] <= wd;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        logic [AW-1:0] addr;
        assign addr = ra[p*AW +: AW];
        assign rd[p*DW +: DW] = (addr == '0) ? '0 : regs_q[addr];
    end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_dp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [2:0]    ctl,
    output logic [DW-1:0] y,
    output logic          is_zero
);
    always_comb begin
        case (alu_op_e'(ctl))
            ALU_ADD: y = op_a + op_b;
            ALU_SUB: y = op_a - op_b;
            ALU_AND: y = op_a & op_b;
            ALU_OR:  y = op_a | op_b;
            ALU_SLT: y = {{(DW-1){1'b0}}, $signed(op_a) < $signed(op_b)};
            default: y = '0;
        endcase
    end

    assign is_zero = (y == '0);
endmodule

// File: rtl/mc_imm_ext.sv
module mc_imm_ext #(
    parameter int DW    = 32,
    parameter int IMM_W = 16,
    parameter int SHIFT = 2
) (
    input  logic [IMM_W-1:0] imm,
    output logic [DW-1:0]    sext,
    output logic [DW-1:0]    sext_sh
);
    assign sext    = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
    assign sext_sh = {sext[DW-SHIFT-1:0], {SHIFT{1'b0}}};
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_dp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_wr,
    input  logic             pc_wr,
    input  logic             pc_wr_cond,
    input  logic [1:0]       pc_src,
    input  logic             addr_sel,
    input  logic             srca_sel,
    input  logic [1:0]       srcb_sel,
    input  logic [2:0]       alu_ctl,
    input  logic             dst_sel,
    input  logic             wb_sel,
    input  logic             rf_wr,
    input  logic             mem_wr,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             mem_we,
    output logic [5:0]       opcode,
    output logic [5:0]       funct
    ,
    output logic             zero
);
    dp_state_t st_q, st_d;

    logic [RIDX_W-1:0]   rs_idx, rt_idx, rd_idx, wr_idx;
    logic [2*XLEN-1:0]   rf_rd;
    logic [XLEN-1:0]     wr_data, imm_sx, imm_sx_sh;
    logic [XLEN-1:0]     alu_a, alu_b, alu_y, jmp_tgt, pc_next;
    logic                alu_zero, pc_load;

    assign rs_idx = st_q.ir[25:21];
    assign rt_idx = st_q.ir[20:16];
    assign rd_idx = st_q.ir[15:11];
    assign wr_idx  = dst_sel ? rd_idx : rt_idx;
    assign wr_data = wb_sel ? st_q.mdr : st_q.alu_out;

    mc_regfile #(.DW(XLEN), .NREGS(REG_CNT), .RD_PORTS(2)) rf_i (
        .clk (clk),
        .ra  ({rt_idx, rs_idx}),
        .rd  (rf_rd),
        .we  (rf_wr),
        .wa  (wr_idx),
        .wd  (wr_data)
    );

    mc_imm_ext #(.DW(XLEN), .IMM_W(16), .SHIFT(2)) ext_i (
        .imm     (st_q.ir[15:0]),
        .sext    (imm_sx),
        .sext_sh (imm_sx_sh)
    );

    always_comb begin
        alu_a = srca_sel ? st_q.a : st_q.pc;
        case (srcb_sel)
            SRCB_REG:  alu_b = st_q.b;
            SRCB_FOUR: alu_b = XLEN'(4);
            SRCB_IMM:  alu_b = imm_sx;
            default:   alu_b = imm_sx_sh;
        endcase
    end

    mc_alu #(.DW(XLEN)) alu_i (
        .op_a    (alu_a),
        .op_b    (alu_b),
        .ctl     (alu_ctl),
        .y       (alu_y),
        .is_zero (alu_zero)
    );

    assign jmp_tgt = {st_q.pc[XLEN-1:XLEN-4], st_q.ir[25:0], 2'b00};

    always_comb begin
        case (pc_src)
            PCS_HELD: pc_next = st_q.alu_out;
            PCS_JMP:  pc_next = jmp_tgt;
            default:  pc_next = alu_y;
        endcase
        pc_load = pc_wr | (pc_wr_cond & alu_zero);

        st_d         = st_q;
        st_d.a       = rf_rd[XLEN-1:0];
        st_d.b       = rf_rd[2*XLEN-1:XLEN];
        st_d.alu_out = alu_y;
        st_d.mdr     = mem_rdata;
        if (ir_wr) begin
            st_d.ir = mem_rdata;
        end
        if (pc_load) begin
            st_d.pc = pc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = addr_sel ? st_q.alu_out : st_q.pc;
    assign mem_wdata = st_q.b;
    assign mem_we    = mem_wr;
    assign opcode    = st_q.ir[31:26];
    assign funct     = st_q.ir[5:0];
    assign zero      = alu_zero;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ir_wr,
    input logic        pc_wr,
    input logic        pc_wr_cond,
    input logic [1:0]  pc_src,
    input logic        srca_sel,
    input logic [1:0]  srcb_sel,
    input logic [2:0]  alu_ctl,
    input logic [31:0] mem_rdata,
    input logic [5:0]  opcode,
    input logic [5:0]  funct,
    input logic        zero,
    input logic [31:0] pc_q,
    input logic [31:0] a_q,
    input logic [31:0] b_q
);
    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> ($stable(opcode) && $stable(funct)));

    // R2
    ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (opcode == $past(mem_rdata[31:26]) && funct == $past(mem_rdata[5:0])));

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && !pc_wr_cond) |=> $stable(pc_q));

    // R8
    pc_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && pc_wr_cond && !zero) |=> $stable(pc_q));

    // R8
    pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'b00 && !srca_sel && srcb_sel == 2'b01 && alu_ctl == 3'b000)
        |=> pc_q == $past(pc_q) + 32'd4);

    // R4
    cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_ctl == 3'b001 && srca_sel && srcb_sel == 2'b00) |-> (zero == (a_q == b_q)));
endmodule

bind mc_datapath mc_datapath_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ir_wr      (ir_wr),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_src     (pc_src),
    .srca_sel   (srca_sel),
    .srcb_sel   (srcb_sel),
    .alu_ctl    (alu_ctl),
    .mem_rdata  (mem_rdata),
    .opcode     (opcode),
    .funct      (funct),
    .zero       (zero),
    .pc_q       (st_q.pc),
    .a_q        (st_q.a),
    .b_q        (st_q.b)
);

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DBASE = 32'h300;

    typedef struct packed {
        logic       ir_wr, pc_wr, pc_wr_cond;
        logic [1:0] pc_src;
        logic       addr_sel, srca_sel;
        logic [1:0] srcb_sel;
        logic [2:0] alu_ctl;
        logic       dst_sel, wb_sel, rf_wr, mem_wr;
    } ctl_t;

    typedef struct packed {
        logic [5:0]  fn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] y;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{6'h20, 32'd5,         32'd7,         32'd12},
        '{6'h22, 32'd7,         32'd7,         32'd0},
        '{6'h24, 32'hF0F0F0F0,  32'h0FF00FF0,  32'h00F000F0},
        '{6'h25, 32'hF0F0F0F0,  32'h0FF00FF0,  32'hFFF0FFF0},
        '{6'h2A, 32'hFFFFFFFD,  32'd2,         32'd1},
        '{6'h2A, 32'd2,         32'hFFFFFFFD,  32'd0},
        '{6'h20, 32'hFFFFFFFF,  32'd1,         32'd0},
        '{6'h22, 32'd3,         32'd5,         32'hFFFFFFFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    ctl_t        ctl = '0;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_we, zero;
    logic [5:0]  opcode, funct;
    logic [31:0] mem [256];
    logic [31:0] exp_rf [32];
    logic [31:0] exp_pc = '0;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    mc_datapath dut_i (
        .clk(clk), .rst_n(rst_n),
        .ir_wr(ctl.ir_wr), .pc_wr(ctl.pc_wr), .pc_wr_cond(ctl.pc_wr_cond),
        .pc_src(ctl.pc_src), .addr_sel(ctl.addr_sel), .srca_sel(ctl.srca_sel),
        .srcb_sel(ctl.srcb_sel), .alu_ctl(ctl.alu_ctl), .dst_sel(ctl.dst_sel),
        .wb_sel(ctl.wb_sel), .rf_wr(ctl.rf_wr), .mem_wr(ctl.mem_wr),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .opcode(opcode), .funct(funct), .zero(zero)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input ctl_t c);
        ctl = c;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [2:0] fn2ctl(input logic [5:0] fn);
        case (fn)
            6'h20: return 3'b000;
            6'h22: return 3'b001;
            6'h24: return 3'b010;
            6'h25: return 3'b011;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Acts as the sequencer; r_res is the expected result of an R-type op.
    task automatic run_instr(input logic [31:0] ins, input logic [31:0] r_res);
        ctl_t c;
        logic [31:0] sx, ea;
        int rs, rt, rd;
        rs = int'(ins[25:21]);
        rt = int'(ins[20:16]);
        rd = int'(ins[15:11]);
        sx = {{16{ins[15]}}, ins[15:0]};
        mem[exp_pc[9:2]] = ins;
        c = '0; c.ir_wr = 1; c.pc_wr = 1; c.srcb_sel = 2'b01;
        apply(c);
        chk(mem_addr, exp_pc, "R1 fetch address is PC");
        tick();
        exp_pc = exp_pc + 32'd4;
        chk({26'd0, opcode}, {26'd0, ins[31:26]}, "R2 opcode after fetch");
        chk({26'd0, funct}, {26'd0, ins[5:0]}, "R2 funct after fetch");
        c = '0; c.srcb_sel = 2'b11;
        apply(c);
        tick();
        ea = exp_rf[rs] + sx;
        case (ins[31:26])
            6'h00: begin
                c = '0; c.srca_sel = 1; c.alu_ctl = fn2ctl(ins[5:0]);
                apply(c); tick();
                c = '0; c.rf_wr = 1; c.dst_sel = 1;
                apply(c); tick();
                if (rd != 0) exp_rf[rd] = r_res;
            end
            6'h23: begin
                c = '0; c.srca_sel = 1; c.srcb_sel = 2'b10;
                apply(c); tick();
                c = '0; c.addr_sel = 1;
                apply(c);
                chk(mem_addr, ea, "R1 R3 load address from held ALU result");
                chk({26'd0, opcode}, {26'd0, ins[31:26]}, "R2 IR holds during data read");
                tick();
                c = '0; c.rf_wr = 1; c.wb_sel = 1;
                apply(c); tick();
                if (rt != 0) exp_rf[rt] = mem[ea[9:2]];
            end
            6'h2B: begin
                c = '0; c.srca_sel = 1; c.srcb_sel = 2'b10;
                apply(c); tick();
                c = '0; c.addr_sel = 1; c.mem_wr = 1;
                apply(c);
                chk(mem_addr, ea, "R1 store address");
                chk({31'd0, mem_we}, 32'd1, "R9 write strobe");
                chk(mem_wdata, exp_rf[rt], "R9 store data from B");
                tick();
                ctl = '0;
            end
            6'h04: begin
                c = '0; c.srca_sel = 1; c.alu_ctl = 3'b001; c.pc_wr_cond = 1; c.pc_src = 2'b01;
                apply(c);
                chk({31'd0, zero}, {31'd0, exp_rf[rs] == exp_rf[rt]}, "R4 zero on compare");
                tick();
                if (exp_rf[rs] == exp_rf[rt]) exp_pc = exp_pc + {sx[29:0], 2'b00};
            end
            default: begin
                c = '0; c.pc_wr = 1; c.pc_src = 2'b10;
                apply(c); tick();
                exp_pc = {exp_pc[31:28], ins[25:0], 2'b00};
            end
        endcase
        ctl = '0;
    endtask

    // Brings a register out through a store to a scratch word.
    task automatic peek_reg(input int r, input logic [31:0] exp, input string tag);
        run_instr(enc_i(6'h2B, 0, r, 16'h03F0), '0);
        chk(mem[8'hFC], exp, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 32; i++) exp_rf[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R10 reset state visible at the ports
        chk(mem_addr, 32'd0, "R10 PC reset");
        chk(mem_wdata, 32'd0, "R10 B reset");
        chk({26'd0, opcode}, 32'd0, "R10 IR reset");
        chk({31'd0, zero}, 32'd1, "R10 R4 zero from cleared operands");

        // Table walk: R3 R4 R5 R6 through load, compute, store
        for (int v = 0; v < 8; v++) begin
            mem[DBASE[9:2]]     = VECS[v].a;
            mem[DBASE[9:2] + 1] = VECS[v].b;
            run_instr(enc_i(6'h23, 0, 1, 16'h0300), '0);
            run_instr(enc_i(6'h23, 0, 2, 16'h0304), '0);
            run_instr(enc_r(VECS[v].fn, 1, 2, 3), VECS[v].y);
            run_instr(enc_i(6'h2B, 0, 3, 16'h0308), '0);
            chk(mem[DBASE[9:2] + 2], VECS[v].y, "R4 R6 ALU result table");
        end

        // R7: write to register 0 is dropped
        run_instr(enc_r(6'h20, 1, 2, 0), 32'd8);
        peek_reg(0, 32'd0, "R7 register 0 reads zero");

        // R3 negative immediate on load
        mem[DBASE[9:2]]     = 32'h0000030C;
        mem[DBASE[9:2] + 2] = 32'hA5A51234;
        run_instr(enc_i(6'h23, 0, 4, 16'h0300), '0);
        run_instr(enc_i(6'h23, 4, 5, 16'hFFFC), '0);
        peek_reg(5, 32'hA5A51234, "R3 R6 load with negative offset");

        // R8 branch not taken, then taken forward
        begin
            logic [31:0] pc0;
            pc0 = exp_pc;
            run_instr(enc_i(6'h04, 4, 5, 16'h0005), '0);
            chk(exp_pc, pc0 + 32'd4, "R8 untaken branch keeps PC+4");
            pc0 = exp_pc;
            run_instr(enc_i(6'h04, 4, 4, 16'h0003), '0);
            chk(exp_pc, pc0 + 32'd16, "R8 taken branch target");
        end

        // R8 jump then backward branch
        run_instr({6'h02, 26'h0000040}, '0);
        chk(exp_pc, 32'h100, "R8 jump target");
        run_instr(enc_i(6'h04, 0, 0, 16'hFFF0), '0);
        chk(exp_pc, 32'hC4, "R8 backward branch target");
        apply('0);
        chk(mem_addr, 32'hC4, "R8 R1 PC after backward branch");

        // R2 IR holds while memory contents change with ir_wr low
        mem[8'h31] = 32'hFFFFFFFF;
        tick();
        chk({26'd0, opcode}, 32'h04, "R2 IR hold with ir_wr low");

        // R5 B captures rt every cycle: after a peek of r4, B shows r4
        peek_reg(4, 32'h0000030C, "R5 R9 register value via store");
        tick();
        chk(mem_wdata, 32'h0000030C, "R5 B reflects rt of held instruction");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule